// File: doc/BRIEF.md
# External Data Memory Bus Controller

This block serves byte-wide data-memory requests from a CPU on a 16-bit address space. On each request it decides whether the access belongs to a small on-chip extra RAM or to memory on a multiplexed external bus. Internal accesses finish in one cycle and cause no bus activity. External accesses run a fixed sequence:

- an address-latch phase, where the low address byte is placed on the shared address/data lines and the high byte on its own lines;
- a setup gap;
- an active-low read or write strobe whose length follows a wait-state setting.

A small auxiliary control register holds four settings: the wait-state count, the size of the internal RAM window (starting at address 0), a bypass that sends every address off-chip, and a quiet option. The quiet option stops the latch-enable line from toggling while the bus is idle. Only the single-cycle timing mode is built. The shared lines are split into an output byte, an output enable and an input byte, so a pad ring can form the bidirectional pins.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset `cfgRdata` reads {1'b0, aleQuiet=0, extOnly=`cfgExtDefault`, sizeSel=3'b010, waitSel=2'b00}. That is 8'h08 when `cfgExtDefault` is 0 and 8'h28 when it is 1. At the same time `rdN` and `wrN` are high, `adOe` is low and `done` is low.
- R2: A write with `cfgWe` stores `cfgWdata[6:0]` with this layout: bit 6 aleQuiet, bit 5 extOnly, bits 4:2 sizeSel, bits 1:0 waitSel. Bit 7 of `cfgRdata` reads 0.
- R3: When extOnly is 0, an address is internal when its upper byte is below the page limit for sizeSel. The limits are 1, 2, 3, 4, 7 and 8 pages of 256 bytes for codes 0 to 5. Codes 6 and 7 use 8 pages (2048 bytes). All other addresses are external.
- R4: When extOnly is 1, every address goes to the external bus.
- R5: An internal access raises `done` in the cycle after `req` is sampled. During it `rdN` and `wrN` stay high and `adOe` stays low. Writes store the byte, and reads return it on `rdata`.
- R6: An external access holds `ale` high for exactly one cycle. In that cycle `adOe` is high, `adOut` carries the low address byte and `addrHi` the high byte. `done` pulses in the cycle after the strobe ends, so the latency is 2+S+W cycles. `ale` is never high while a strobe is low.
- R7: The setup S, counted in cycles between `ale` falling and the strobe falling, is 1, 1, 2 and 2 for waitSel 0, 1, 2 and 3.
- R8: The strobe width W is 1, 2, 2 and 3 cycles for waitSel 0, 1, 2 and 3.
- R9: An external write uses only `wrN`. It drives `cpuWdata` on `adOut` with `adOe` high for every strobe cycle.
- R10: An external read uses only `rdN` and keeps `adOe` low during the strobe. `rdata` takes `adIn` as sampled at the clock edge that ends the strobe.
- R11: When aleQuiet is 0, an idle bus toggles `ale` every cycle (half the clock rate). When aleQuiet is 1, `ale` stays low except in the address phase of an external access.
- R12: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgExtDefault | input | 1 | Reset value of the external-only bit |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 8 | Control register write data |
| cfgRdata | output | 8 | Control register contents |
| req | input | 1 | Access request, sampled when idle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Access address |
| cpuWdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the last read |
| done | output | 1 | One-cycle completion pulse |
| ale | output | 1 | Address latch enable, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| adOut | output | 8 | Multiplexed low address / write data |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | 8 | Multiplexed read data from the pins |
| addrHi | output | 8 | High address byte |

## Verification
The bench sweeps every wait-state code for both reads and writes and measures the address, setup and strobe phases cycle by cycle. A table lookup off by one would show up as a wrong phase count. A design that sampled read data early would capture the bench's filler byte instead of the address-derived value.

For every size code, with the bypass both off and on, the bench accesses the last address inside the window and the first address beyond it. A wrong limit, or a reserved code left unhandled, would send an access to the wrong side. That shows in the latency, and in internal data that fails to read back.

Reset is applied with both configuration defaults, and the latch-enable line is watched idle in both quiet settings.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef struct packed {
    logic       aleQuiet;
    logic       extOnly;
    logic [2:0] sizeSel;
    logic [1:0] waitSel;
  } cfgT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE
  } stateT;

  // Strobes from control to datapath/top
  typedef struct packed {
    logic capture;
    logic memAccess;
    logic sampleBus;
    logic driveAddr;
    logic driveData;
    logic rdOn;
    logic wrOn;
    logic aleOn;
  } strobeT;

endpackage

// File: rtl/xmem_datapath.sv
module xmem_datapath
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MEM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgExtDefault,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  strobeT            ctl,
  input  logic [DATA_W-1:0] adIn,
  output logic              isInternal,
  output logic [1:0]        waitSel,
  output logic              aleQuiet,
  output logic              weCap,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-9:0] addrHi,
  output logic [DATA_W-1:0] rdata
);
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int PAGE_W = ADDR_W - 8;

  cfgT cfg;
  logic [ADDR_W-1:0] addrCap;
  logic [DATA_W-1:0] wdataCap;
  logic [DATA_W-1:0] mem [MEM_BYTES];
  logic [PAGE_W-1:0] pageLimit;

  // Pages of 256 bytes covered by the internal window
  always_comb begin
    case (cfg.sizeSel)
      3'd0:    pageLimit = PAGE_W'(1);
      3'd1:    pageLimit = PAGE_W'(2);
      3'd2:    pageLimit = PAGE_W'(3);
      3'd3:    pageLimit = PAGE_W'(4);
      3'd4:    pageLimit = PAGE_W'(7);
      default: pageLimit = PAGE_W'(8);
    endcase
  end

  assign isInternal = !cfg.extOnly && (cpuAddr[ADDR_W-1:8] < pageLimit);
  assign waitSel    = cfg.waitSel;
  assign aleQuiet   = cfg.aleQuiet;
  assign cfgRdata   = {1'b0, cfg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '{aleQuiet: 1'b0, extOnly: cfgExtDefault, sizeSel: 3'b010, waitSel: 2'b00};
    end else if (cfgWe) begin
      cfg <= cfgT'(cfgWdata[6:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCap  <= '0;
      wdataCap <= '0;
      weCap    <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctl.capture) begin
        addrCap  <= cpuAddr;
        wdataCap <= cpuWdata;
        weCap    <= cpuWe;
      end
      if (ctl.memAccess && !cpuWe) rdata <= mem[cpuAddr[MEM_AW-1:0]];
      else if (ctl.sampleBus)      rdata <= adIn;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.memAccess && cpuWe) mem[cpuAddr[MEM_AW-1:0]] <= cpuWdata;
  end

  assign adOut  = ctl.driveAddr ? addrCap[DATA_W-1:0] : wdataCap;
  assign adOe   = ctl.driveAddr || ctl.driveData;
  assign addrHi = addrCap[ADDR_W-1:8];

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       isInternal,
  input  logic [1:0] waitSel,
  input  logic       aleQuiet,
  input  logic       weCap,
  output strobeT     ctl,
  output logic       done
);
  stateT      state;
  logic [1:0] cnt;
  logic [1:0] wsCap;
  logic       aleTog;
  logic [1:0] setupLen;
  logic [1:0] strobeLen;

  // Setup 1,1,2,2 and width 1,2,2,3 for codes 0..3
  assign setupLen  = 2'd1 + {1'b0, wsCap[1]};
  assign strobeLen = 2'd1 + {1'b0, wsCap[1]} + {1'b0, wsCap[0]};

  always_comb begin
    ctl           = '0;
    ctl.capture   = (state == ST_IDLE) && req && !isInternal;
    ctl.memAccess = (state == ST_IDLE) && req && isInternal;
    ctl.driveAddr = (state == ST_ADDR);
    ctl.driveData = weCap && ((state == ST_SETUP) || (state == ST_STROBE));
    ctl.rdOn      = (state == ST_STROBE) && !weCap;
    ctl.wrOn      = (state == ST_STROBE) && weCap;
    ctl.sampleBus = (state == ST_STROBE) && !weCap && (cnt == 2'd0);
    ctl.aleOn     = (state == ST_ADDR) || ((state == ST_IDLE) && !aleQuiet && aleTog);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wsCap  <= '0;
      done   <= 1'b0;
      aleTog <= 1'b0;
    end else begin
      done   <= 1'b0;
      aleTog <= !aleTog;
      case (state)
        ST_IDLE: begin
          if (req) begin
            if (isInternal) begin
              done <= 1'b1;
            end else begin
              state <= ST_ADDR;
              wsCap <= waitSel;
            end
          end
        end
        ST_ADDR: begin
          state <= ST_SETUP;
          cnt   <= setupLen - 2'd1;
        end
        ST_SETUP: begin
          if (cnt == 2'd0) begin
            state <= ST_STROBE;
            cnt   <= strobeLen - 2'd1;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: begin
          if (cnt == 2'd0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MEM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgExtDefault,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              req,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-9:0] addrHi
);
  strobeT     ctl;
  logic       isInternal;
  logic [1:0] waitSel;
  logic       aleQuiet;
  logic       weCap;

  xmem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .isInternal(isInternal),
    .waitSel(waitSel), .aleQuiet(aleQuiet), .weCap(weCap),
    .ctl(ctl), .done(done)
  );

  xmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .cfgExtDefault(cfgExtDefault), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .ctl(ctl), .adIn(adIn), .isInternal(isInternal),
    .waitSel(waitSel), .aleQuiet(aleQuiet), .weCap(weCap), .adOut(adOut),
    .adOe(adOe), .addrHi(addrHi), .rdata(rdata)
  );

  assign ale = ctl.aleOn;
  assign rdN = !ctl.rdOn;
  assign wrN = !ctl.wrOn;

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgRdata,
  input logic       done,
  input logic       ale,
  input logic       rdN,
  input logic       wrN,
  input logic       adOe
);
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r6_no_ale_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !ale);

  a_r9_write_drives_bus: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe);

  a_r10_read_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  a_r11_quiet_ale_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[6] && !adOe) |-> !ale);

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgRdata(cfgRdata), .done(done),
  .ale(ale), .rdN(rdN), .wrN(wrN), .adOe(adOe)
);

// File: tb/xmem_bus_ctrl_tb.sv
module xmem_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgExtDefault = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        req = 1'b0;
  logic        cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  rdata;
  logic        done, ale, rdN, wrN, adOe;
  logic [7:0]  adOut, adIn, addrHi;

  int errors = 0;
  int checks = 0;

  // measurements of the last access
  int lat, aleN, setN, strN;
  bit driveOk, addrOk;

  // external memory model
  logic [15:0] latched = '0;
  logic [15:0] lastWrA = '0;
  logic [7:0]  lastWrD = '0;

  always #4 clk = !clk;

  xmem_bus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgExtDefault(cfgExtDefault), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .req(req), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .rdata(rdata), .done(done),
    .ale(ale), .rdN(rdN), .wrN(wrN), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .addrHi(addrHi)
  );

  always @(posedge clk) begin
    if (ale && adOe) latched <= {addrHi, adOut};
    if (!wrN) begin
      lastWrA <= latched;
      lastWrD <= adOut;
    end
  end
  assign adIn = !rdN ? (latched[7:0] ^ latched[15:8] ^ 8'h5A) : 8'hEE;

  function automatic logic [7:0] extVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; cpuWe = w; cpuAddr = a; cpuWdata = d;
    lat = 0; aleN = 0; setN = 0; strN = 0; driveOk = 1; addrOk = 1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      lat = k;
      if (done) break;
      if (ale) begin
        aleN++;
        if (adOut !== a[7:0] || addrHi !== a[15:8] || !adOe) addrOk = 0;
      end else if (!rdN || !wrN) begin
        strN++;
        if (w && (!adOe || adOut !== d || !rdN)) driveOk = 0;
        if (!w && (adOe || !wrN)) driveOk = 0;
      end else if (aleN > 0) begin
        setN++;
      end
      @(negedge clk);
    end
  endtask

  task automatic doReset(input bit extDef);
    @(negedge clk);
    rstN = 1'b0;
    cfgExtDefault = extDef;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int expS, expW;
    logic [7:0] cv;
    bit prevAle;

    doReset(1'b0);
    // R1 reset state
    check(cfgRdata == 8'h08, $sformatf("R1 cfgRdata act=%h exp=08", cfgRdata));
    check(rdN && wrN && !adOe && !done,
          $sformatf("R1 idle outputs rdN=%b wrN=%b adOe=%b done=%b exp 1 1 0 0", rdN, wrN, adOe, done));

    // R11 idle toggling with quiet off
    prevAle = ale;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ale == !prevAle, $sformatf("R11 toggle act=%b exp=%b", ale, !prevAle));
      prevAle = ale;
    end

    // R2 register layout
    cfgWrite(8'hFF);
    check(cfgRdata == 8'h7F, $sformatf("R2 readback act=%h exp=7f", cfgRdata));
    cfgWrite(8'h49);
    check(cfgRdata == 8'h49, $sformatf("R2 readback act=%h exp=49", cfgRdata));

    // R11 quiet idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!ale, $sformatf("R11 quiet ale act=%b exp=0", ale));
    end

    // R6 R7 R8 R9 R10 wait-state sweep
    for (int ws = 0; ws < 4; ws++) begin
      expS = (ws >= 2) ? 2 : 1;
      expW = (ws == 0) ? 1 : ((ws == 3) ? 3 : 2);
      cfgWrite(8'h48 | 8'(ws));
      for (int p = 0; p < 3; p++) begin
        logic [15:0] ra;
        logic [15:0] wa;
        logic [7:0]  wd;
        ra = 16'h1234 + 16'(p * 16'h1111) + 16'(ws);
        wa = 16'hABCD - 16'(p * 16'h0F0F) - 16'(ws);
        wd = 8'(ws * 17 + p * 5 + 3);
        access(1'b0, ra, 8'h00);
        check(lat == 2 + expS + expW, $sformatf("R6 ws=%0d read latency act=%0d exp=%0d", ws, lat, 2 + expS + expW));
        check(aleN == 1 && addrOk, $sformatf("R6 ws=%0d ale cycles act=%0d exp=1 addrOk=%b", ws, aleN, addrOk));
        check(setN == expS, $sformatf("R7 ws=%0d read setup act=%0d exp=%0d", ws, setN, expS));
        check(strN == expW, $sformatf("R8 ws=%0d read width act=%0d exp=%0d", ws, strN, expW));
        check(driveOk, $sformatf("R10 ws=%0d bus released act=%b exp=1", ws, driveOk));
        check(rdata == extVal(ra), $sformatf("R10 ws=%0d rdata act=%h exp=%h", ws, rdata, extVal(ra)));
        access(1'b1, wa, wd);
        check(lat == 2 + expS + expW, $sformatf("R6 ws=%0d write latency act=%0d exp=%0d", ws, lat, 2 + expS + expW));
        check(setN == expS, $sformatf("R7 ws=%0d write setup act=%0d exp=%0d", ws, setN, expS));
        check(strN == expW, $sformatf("R8 ws=%0d write width act=%0d exp=%0d", ws, strN, expW));
        check(driveOk, $sformatf("R9 ws=%0d write drive act=%b exp=1", ws, driveOk));
        check(lastWrA == wa && lastWrD == wd,
              $sformatf("R9 ws=%0d ext write act=%h/%h exp=%h/%h", ws, lastWrA, lastWrD, wa, wd));
      end
    end

    // R3 R4 R5 size sweep
    for (int ex = 0; ex < 2; ex++) begin
      for (int sz = 0; sz < 8; sz++) begin
        int lim;
        logic [15:0] inA;
        logic [15:0] outA;
        logic [7:0] d;
        lim = (sz < 4) ? sz + 1 : ((sz == 4) ? 7 : 8);
        inA = 16'(lim * 256 - 1);
        outA = 16'(lim * 256);
        d = 8'(sz * 29 + ex * 101 + 7);
        cv = {1'b0, 1'b1, 1'(ex), 3'(sz), 2'b00};
        cfgWrite(cv);
        access(1'b1, inA, d);
        if (ex == 0) begin
          check(lat == 1, $sformatf("R3 sz=%0d inside write latency act=%0d exp=1", sz, lat));
          check(rdN && wrN && !adOe && !ale,
                $sformatf("R5 sz=%0d internal no bus rdN=%b wrN=%b adOe=%b ale=%b", sz, rdN, wrN, adOe, ale));
          access(1'b0, inA, 8'h00);
          check(lat == 1 && rdata == d, $sformatf("R5 sz=%0d internal read act=%h lat=%0d exp=%h lat=1", sz, rdata, lat, d));
        end else begin
          check(lat == 4, $sformatf("R4 sz=%0d ext-only inside latency act=%0d exp=4", sz, lat));
          check(lastWrA == inA && lastWrD == d, $sformatf("R4 sz=%0d ext write act=%h exp=%h", sz, lastWrA, inA));
          access(1'b0, 16'h0000, 8'h00);
          check(lat == 4 && rdata == extVal(16'h0000), $sformatf("R4 sz=%0d addr0 read act=%h lat=%0d exp=%h lat=4", sz, rdata, lat, extVal(16'h0000)));
        end
        access(1'b0, outA, 8'h00);
        check(lat == 4 && rdata == extVal(outA),
              $sformatf("R3 sz=%0d outside read act=%h lat=%0d exp=%h lat=4", sz, rdata, lat, extVal(outA)));
      end
    end

    // R12 done single pulse after internal access
    cfgWrite(8'h48);
    access(1'b0, 16'h0010, 8'h00);
    @(negedge clk);
    check(!done, $sformatf("R12 done width act=%b exp=0", done));

    // R1 reset with external-only default
    doReset(1'b1);
    check(cfgRdata == 8'h28, $sformatf("R1 cfgRdata ext default act=%h exp=28", cfgRdata));
    access(1'b0, 16'h0005, 8'h00);
    check(lat == 4, $sformatf("R1 default ext-only latency act=%0d exp=4", lat));

    summary();
    $finish;
  end

endmodule